// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating Controller

This block sits between a clock synthesiser's source clocks and the board-level clock pins. It turns a set of processor, PCI, graphics-port, memory, reference and 48 MHz clocks into gated outputs. It stops groups of those outputs on active-low requests from four shared pins. A mode strap is captured during reset. In mobile mode the four shared pins are stop and power-down request inputs. In desktop mode the same pins drive extra memory-clock copies and every pin request is ignored.

Each gated output has its own gating machine with two states, `GATE_HALTED` and `GATE_RUNNING`. The request reaches the machine through a synchroniser in that output's clock domain. The machine changes state only on the falling edge of its source clock. A clock therefore stops or restarts only during its low phase and always rests low. The transition from `GATE_HALTED` to `GATE_RUNNING` occurs when the synchronised run request is high. The transition from `GATE_RUNNING` to `GATE_HALTED` occurs when it is low. Reset forces `GATE_HALTED`. Every stoppable output also has a per-output enable input, for example from a register bank. That enable uses the same gating path.

Top module: `clkgate_ctrl`

## Requirements
- R1: The mode strap is sampled on reference-clock edges only while `rst_n` is low. Strap changes after reset leave the pin functions unchanged.
- R2: The strap sets the pin functions. With strap 0 (mobile), `pin_oe_o` is 0, `pin_clk_o` is low and the pins act as requests. With strap 1 (desktop), `pin_oe_o` is all ones, `pin_clk_o` carries the memory clock, and the request pins have no effect on any output.
- R3: In mobile mode, pin bit 0 low (processor stop) holds every `cpu_clk_o` bit low.
- R4: In mobile mode, pin bit 1 low holds every `pci_clk_o` bit low. `pci_free_o` keeps toggling.
- R5: In mobile mode, pin bit 2 low holds `agp_clk_o` bits 1 and up low. `agp_clk_o[0]` keeps toggling.
- R6: In mobile mode, pin bit 3 low (power-down) holds every clock output low, including the free PCI clock, `agp_clk_o[0]`, the memory, reference and 48 MHz clocks.
- R7: The memory, reference and 48 MHz outputs keep toggling under any combination of pin bits 0 to 2.
- R8: An enable bit of 0 holds its own output low. With enable 1 the output follows the stop requests. Enable bit k of `cpu_en_i`/`pci_en_i` maps to output bit k. Enable bit k of `agp_en_i` maps to `agp_clk_o[k+1]`.
- R9: While `rst_n` is low, every clock output is low.
- R10: Gating never shortens a pulse. Each gated machine changes state only on the falling edge of its source clock and follows its synchronised run request. Every high pulse on an output is as wide as the source clock's high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| mode_strap_i | input | 1 | Mode strap: 0 mobile, 1 desktop |
| cpu_clk_i | input | 1 | Processor source clock |
| pci_clk_i | input | 1 | PCI source clock |
| agp_clk_i | input | 1 | Graphics-port source clock |
| sdram_clk_i | input | 1 | Memory source clock |
| ref_clk_i | input | 1 | Reference clock, also samples the strap |
| usb_clk_i | input | 1 | 48 MHz source clock |
| req_pin_i | input | 4 | Shared pins as inputs: bit0 CPU stop, bit1 PCI stop, bit2 AGP stop, bit3 power-down, all active low |
| cpu_en_i | input | N_CPU | Per-output enables for processor clocks |
| pci_en_i | input | N_PCI | Per-output enables for stoppable PCI clocks |
| agp_en_i | input | N_AGP-1 | Per-output enables for graphics clocks 1 and up |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_clk_o | output | N_PCI | Gated stoppable PCI clocks |
| pci_free_o | output | 1 | Free-running PCI clock, stopped only by power-down |
| agp_clk_o | output | N_AGP | Graphics clocks, bit 0 not stoppable by pin |
| sdram_clk_o | output | N_SDR | Memory clocks |
| ref_clk_o | output | 1 | Reference clock output |
| usb_clk_o | output | 1 | 48 MHz clock output |
| pin_clk_o | output | 4 | Memory-clock copies driven onto the shared pins |
| pin_oe_o | output | 4 | Output enables of the shared pins |

## Verification
The bench builds the block with two processor clocks, three stoppable PCI clocks, three graphics clocks and two memory clocks. These values are small enough to sweep all sixteen pin patterns against four enable patterns in mobile mode and two in desktop mode. Expected running-or-held-low results are derived arithmetically from the pin bits, strap and enables. They are compared group by group against toggle observations. Pulse widths on a processor clock and a PCI clock are timed across the whole sweep, so a truncated pulse at any stop entry or exit shows up.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    // State of one output's gating machine
    typedef enum logic {
        GATE_HALTED  = 1'b0,
        GATE_RUNNING = 1'b1
    } gate_state_t;

    // Bit positions of the shared request pins
    localparam int PIN_CPU = 0;
    localparam int PIN_PCI = 1;
    localparam int PIN_AGP = 2;
    localparam int PIN_PD  = 3;
    localparam int N_PINS  = 4;

endpackage

// File: rtl/clkgate_sync.sv
`timescale 1ns/1ps
module clkgate_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkgate_cell.sv
`timescale 1ns/1ps
module clkgate_cell
    import clkgate_pkg::*;
#(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_n,
    input  logic [W-1:0] run_i,
    output logic [W-1:0] clk_o
);

    logic [W-1:0] run_s;

    clkgate_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (run_i),
        .q_o   (run_s)
    );

    for (genvar k = 0; k < W; k++) begin : g_gate
        gate_state_t st_q;
        gate_state_t st_d;

        // Next-state decision
        always_comb begin
            st_d = st_q;
            unique case (st_q)
                GATE_HALTED:  if (run_s[k])  st_d = GATE_RUNNING;
                GATE_RUNNING: if (!run_s[k]) st_d = GATE_HALTED;
                default:                     st_d = GATE_HALTED;
            endcase
        end

        // State register: updates only as the source clock falls
        always_ff @(negedge clk_i or negedge rst_n) begin
            if (!rst_n) st_q <= GATE_HALTED;
            else        st_q <= st_d;
        end

        // Output: source passes only in the running state
        assign clk_o[k] = clk_i & (st_q == GATE_RUNNING);

        // R10
        run_enters_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
            run_s[k] |=> (st_q == GATE_RUNNING));

        // R10
        halt_enters_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
            !run_s[k] |=> (st_q == GATE_HALTED));
    end

endmodule

// File: rtl/clkgate_ctrl.sv
`timescale 1ns/1ps
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int N_PCI  = 6,
    parameter int N_AGP  = 3,
    parameter int N_SDR  = 9,
    parameter int STAGES = 2
) (
    input  logic               rst_n,
    input  logic               mode_strap_i,
    input  logic               cpu_clk_i,
    input  logic               pci_clk_i,
    input  logic               agp_clk_i,
    input  logic               sdram_clk_i,
    input  logic               ref_clk_i,
    input  logic               usb_clk_i,
    input  logic [3:0]         req_pin_i,
    input  logic [N_CPU-1:0]   cpu_en_i,
    input  logic [N_PCI-1:0]   pci_en_i,
    input  logic [N_AGP-2:0]   agp_en_i,
    output logic [N_CPU-1:0]   cpu_clk_o,
    output logic [N_PCI-1:0]   pci_clk_o,
    output logic               pci_free_o,
    output logic [N_AGP-1:0]   agp_clk_o,
    output logic [N_SDR-1:0]   sdram_clk_o,
    output logic               ref_clk_o,
    output logic               usb_clk_o,
    output logic [3:0]         pin_clk_o,
    output logic [3:0]         pin_oe_o
);

    localparam int N_AGP_G = N_AGP - 1;
    localparam int W_PCI   = N_PCI + 1;
    localparam int W_MEM   = N_SDR + N_PINS;

    // Strap capture: follows the strap only while reset is held
    logic desktop_q;
    always_ff @(posedge ref_clk_i) begin
        if (!rst_n) desktop_q <= mode_strap_i;
    end

    // Active-high stop requests; only meaningful in mobile mode
    logic [N_PINS-1:0] stop_req;
    assign stop_req = {N_PINS{~desktop_q}} & ~req_pin_i;

    logic pd_req;
    logic cpu_go, pci_go, agp_go;
    assign pd_req = stop_req[PIN_PD];
    assign cpu_go = ~stop_req[PIN_CPU] & ~pd_req;
    assign pci_go = ~stop_req[PIN_PCI] & ~pd_req;
    assign agp_go = ~stop_req[PIN_AGP] & ~pd_req;

    // Run requests per domain
    logic [N_CPU-1:0] cpu_run;
    logic [W_PCI-1:0] pci_run;
    logic [N_AGP-1:0] agp_run;
    logic [W_MEM-1:0] mem_run;
    assign cpu_run = cpu_en_i & {N_CPU{cpu_go}};
    assign pci_run = {~pd_req, pci_en_i & {N_PCI{pci_go}}};
    assign agp_run = {agp_en_i & {N_AGP_G{agp_go}}, ~pd_req};
    assign mem_run = {{N_PINS{desktop_q & ~pd_req}}, {N_SDR{~pd_req}}};

    clkgate_cell #(.W(N_CPU), .STAGES(STAGES)) u_cpu (
        .clk_i (cpu_clk_i), .rst_n (rst_n), .run_i (cpu_run), .clk_o (cpu_clk_o)
    );

    logic [W_PCI-1:0] pci_all;
    clkgate_cell #(.W(W_PCI), .STAGES(STAGES)) u_pci (
        .clk_i (pci_clk_i), .rst_n (rst_n), .run_i (pci_run), .clk_o (pci_all)
    );
    assign pci_clk_o  = pci_all[N_PCI-1:0];
    assign pci_free_o = pci_all[N_PCI];

    clkgate_cell #(.W(N_AGP), .STAGES(STAGES)) u_agp (
        .clk_i (agp_clk_i), .rst_n (rst_n), .run_i (agp_run), .clk_o (agp_clk_o)
    );

    logic [W_MEM-1:0] mem_all;
    clkgate_cell #(.W(W_MEM), .STAGES(STAGES)) u_mem (
        .clk_i (sdram_clk_i), .rst_n (rst_n), .run_i (mem_run), .clk_o (mem_all)
    );
    assign sdram_clk_o = mem_all[N_SDR-1:0];
    assign pin_clk_o   = mem_all[W_MEM-1:N_SDR];

    clkgate_cell #(.W(1), .STAGES(STAGES)) u_ref (
        .clk_i (ref_clk_i), .rst_n (rst_n), .run_i (~pd_req), .clk_o (ref_clk_o)
    );

    clkgate_cell #(.W(1), .STAGES(STAGES)) u_usb (
        .clk_i (usb_clk_i), .rst_n (rst_n), .run_i (~pd_req), .clk_o (usb_clk_o)
    );

    assign pin_oe_o = {N_PINS{desktop_q}};

    // R1
    strap_hold_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        $stable(desktop_q));

    // R2
    desktop_no_stop_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_n)
        (pin_oe_o == 4'hF) |-> (stop_req == '0));

endmodule

// File: tb/tb_clkgate_ctrl.sv
`timescale 1ns/100ps
module tb_clkgate_ctrl;

    localparam int N_CPU = 2;
    localparam int N_PCI = 3;
    localparam int N_AGP = 3;
    localparam int N_SDR = 2;
    localparam int NO    = 17;

    localparam logic [NO-1:0] M_CPU  = 17'h00003;
    localparam logic [NO-1:0] M_PCI  = 17'h0001C;
    localparam logic [NO-1:0] M_FREE = 17'h00060;
    localparam logic [NO-1:0] M_AGPG = 17'h00180;
    localparam logic [NO-1:0] M_KEEP = 17'h18600;
    localparam logic [NO-1:0] M_PIN  = 17'h07800;

    logic clk = 1'b0;
    logic pci_src = 1'b0;
    logic ref_src = 1'b0;
    logic usb_src = 1'b0;
    logic [1:0] div = '0;
    logic rst_n = 1'b0;
    logic strap = 1'b0;
    logic [3:0] pins = 4'hF;
    logic [N_CPU-1:0] cpu_en = '1;
    logic [N_PCI-1:0] pci_en = '1;
    logic [N_AGP-2:0] agp_en = '1;

    logic [N_CPU-1:0] cpu_o;
    logic [N_PCI-1:0] pci_o;
    logic pci_free;
    logic [N_AGP-1:0] agp_o;
    logic [N_SDR-1:0] sdr_o;
    logic ref_o, usb_o;
    logic [3:0] pin_o, pin_oe;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;
    always #7  usb_src = ~usb_src;
    always @(posedge clk) begin
        div <= div + 2'd1;
        pci_src <= ~pci_src;
        if (div[0]) ref_src <= ~ref_src;
    end

    clkgate_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP), .N_SDR(N_SDR)) dut (
        .rst_n (rst_n), .mode_strap_i (strap),
        .cpu_clk_i (clk), .pci_clk_i (pci_src), .agp_clk_i (clk),
        .sdram_clk_i (clk), .ref_clk_i (ref_src), .usb_clk_i (usb_src),
        .req_pin_i (pins), .cpu_en_i (cpu_en), .pci_en_i (pci_en), .agp_en_i (agp_en),
        .cpu_clk_o (cpu_o), .pci_clk_o (pci_o), .pci_free_o (pci_free),
        .agp_clk_o (agp_o), .sdram_clk_o (sdr_o), .ref_clk_o (ref_o),
        .usb_clk_o (usb_o), .pin_clk_o (pin_o), .pin_oe_o (pin_oe)
    );

    logic [NO-1:0] obs;
    assign obs = {usb_o, ref_o, pin_o, sdr_o, agp_o, pci_free, pci_o, cpu_o};

    // Pulse-width monitors for R10
    logic mon_en = 1'b0;
    realtime t_mon = 0.0;
    realtime t_cpu = 0.0;
    realtime t_pci = 0.0;
    int bad_pulses = 0;
    int good_pulses = 0;
    always @(posedge cpu_o[0]) t_cpu = $realtime;
    always @(negedge cpu_o[0])
        if (mon_en && t_cpu > t_mon) begin
            if (($realtime - t_cpu) < 9.9 || ($realtime - t_cpu) > 10.1) bad_pulses++;
            else good_pulses++;
        end
    always @(posedge pci_o[0]) t_pci = $realtime;
    always @(negedge pci_o[0])
        if (mon_en && t_pci > t_mon) begin
            if (($realtime - t_pci) < 19.9 || ($realtime - t_pci) > 20.1) bad_pulses++;
            else good_pulses++;
        end

    task automatic observe(output logic [NO-1:0] hi, output logic [NO-1:0] lo);
        hi = '0;
        lo = '0;
        @(posedge clk);
        #2.5;
        for (int i = 0; i < 40; i++) begin
            hi = hi | obs;
            lo = lo | ~obs;
            #5;
        end
    endtask

    task automatic check_group(input string tag, input logic [NO-1:0] mask,
                               input logic [NO-1:0] hi, input logic [NO-1:0] lo,
                               input logic [NO-1:0] run_exp);
        logic [NO-1:0] good;
        good = (run_exp & hi & lo) | (~run_exp & ~hi);
        checks++;
        if ((~good & mask) != '0) begin
            fails++;
            $display("FAIL %s pins=%b toggling=%h high_seen=%h expected_running=%h mask=%h",
                     tag, pins, hi & lo & mask, hi & mask, run_exp & mask, mask);
        end
    endtask

    // Expected running set from the requirements
    function automatic logic [NO-1:0] expect_run(input logic desk, input logic [3:0] p,
                                                 input logic [6:0] e);
        logic mob, cs, ps, as_, pd;
        logic [NO-1:0] v;
        mob = ~desk;
        cs  = mob & ~p[0];
        ps  = mob & ~p[1];
        as_ = mob & ~p[2];
        pd  = mob & ~p[3];
        v = '0;
        v[1:0]   = e[1:0] & {2{~cs & ~pd}};
        v[4:2]   = e[4:2] & {3{~ps & ~pd}};
        v[5]     = ~pd;
        v[6]     = ~pd;
        v[8:7]   = e[6:5] & {2{~as_ & ~pd}};
        v[10:9]  = {2{~pd}};
        v[14:11] = {4{desk}};
        v[15]    = ~pd;
        v[16]    = ~pd;
        return v;
    endfunction

    task automatic run_combo(input logic desk, input logic [3:0] p, input logic [6:0] e);
        logic [NO-1:0] hi, lo, ex;
        logic pd;
        pins   = p;
        cpu_en = e[1:0];
        pci_en = e[4:2];
        agp_en = e[6:5];
        repeat (25) @(posedge clk);
        observe(hi, lo);
        ex = expect_run(desk, p, e);
        pd = ~desk & ~p[3];
        if (pd) begin
            check_group("R6", '1, hi, lo, ex);
        end else if (desk) begin
            check_group("R2", '1, hi, lo, ex);
        end else begin
            check_group((e[1:0] != 2'b11) ? "R8" : "R3", M_CPU, hi, lo, ex);
            check_group((e[4:2] != 3'b111) ? "R8" : "R4", M_PCI, hi, lo, ex);
            check_group("R5", M_FREE, hi, lo, ex);
            check_group((e[6:5] != 2'b11) ? "R8" : "R5", M_AGPG, hi, lo, ex);
            check_group("R7", M_KEEP, hi, lo, ex);
            check_group("R2", M_PIN, hi, lo, ex);
        end
        checks++;
        if (pin_oe !== {4{desk}}) begin
            fails++;
            $display("FAIL R2 pin_oe=%b expected=%b", pin_oe, {4{desk}});
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [NO-1:0] hi, lo;
        logic [6:0] pats [4];
        pats[0] = 7'h7F; pats[1] = 7'h00; pats[2] = 7'h55; pats[3] = 7'h2A;

        // R9: outputs low while reset is held
        rst_n = 1'b0;
        strap = 1'b0;
        repeat (20) @(posedge clk);
        observe(hi, lo);
        check_group("R9", '1, hi, lo, '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (30) @(posedge clk);
        t_mon  = $realtime;
        mon_en = 1'b1;

        // Mobile sweep: every pin pattern against every enable pattern
        for (int pi = 0; pi < 4; pi++)
            for (int p = 0; p < 16; p++)
                run_combo(1'b0, p[3:0], pats[pi]);

        // R1: strap change after reset must not alter pin function
        strap = 1'b1;
        repeat (10) @(posedge clk);
        checks++;
        if (pin_oe !== 4'h0) begin
            fails++;
            $display("FAIL R1 pin_oe=%b expected=0000", pin_oe);
        end
        run_combo(1'b0, 4'b1110, 7'h7F);
        run_combo(1'b0, 4'b0111, 7'h7F);

        // Desktop: reset with strap high
        mon_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (30) @(posedge clk);
        t_mon  = $realtime;
        mon_en = 1'b1;
        for (int pi = 0; pi < 4; pi += 2)
            for (int p = 0; p < 16; p++)
                run_combo(1'b1, p[3:0], pats[pi]);

        // R10: every observed gated pulse kept its full width
        checks++;
        if (bad_pulses != 0 || good_pulses == 0) begin
            fails++;
            $display("FAIL R10 bad_pulses=%0d good_pulses=%0d expected bad=0 good>0",
                     bad_pulses, good_pulses);
        end
        finish_run();
    end

endmodule